// File: doc/BRIEF.md
# TDM Time-Slot Serial Interface

This block connects one time-division-multiplexed serial link to a set of logical byte channels. The link has four wires: a bit clock, a frame sync, a receive data line and a transmit data line. All four are brought into the system clock domain through synchronizers, and the block works on the detected bit-clock edges. Frame sync is active high and is sampled on the rising bit-clock edge. The first data bit of a frame follows one bit clock after the sync is seen. Receive data is sampled on rising edges. Transmit data changes after falling edges.

Two small routing tables, one for each direction, are written through a simple register port. Each frame is walked through its table one entry per one-byte slot. Every entry names a channel and can carry an end flag. On receive, each completed slot byte is presented for one system cycle together with the channel from its table entry. On transmit, the block fetches one byte per slot from the entry's channel through a ready/valid lane and shifts it out. If no byte is ready, it sends all ones and flags an underrun for that channel. Nothing moves on the link until the global enable is set.

Top module: `tdm_slot_if`

## Requirements
- R1: After reset, `rx_valid`, `tx_ready`, `tx_underrun` and `tdm_txd` are all 0, and the block is disabled.
- R2: While the enable bit (bit 0 written at `cfg_addr` = 2*DEPTH) is 0, no `rx_valid` or `tx_ready` pulse occurs and `tdm_txd` stays 0, whatever the link inputs do.
- R3: Sync high at a rising bit-clock edge makes the next eight rising edges one slot byte, most significant bit first. The byte appears on `rx_data` with `rx_valid` high for exactly one system cycle.
- R4: Receive slot k is tagged with bits [CH_W-1:0] of receive table entry k. An entry with bit CH_W (the end flag) set is the final slot of the frame, and later bits are ignored until the next sync.
- R5: A table with no end flag set ends its walk after entry DEPTH-1.
- R6: Each transmit slot byte is sent most significant bit first, one bit after each falling edge. The first bit follows the first falling edge after the rising edge that saw the sync.
- R7: Each transmit slot gives exactly one one-cycle `tx_ready` pulse on the entry's channel. The byte is taken from lane `tx_data[ch*8 +: 8]`.
- R8: If `tx_valid[ch]` is low at the fetch, the slot sends 0xFF and `tx_underrun[ch]` pulses for one cycle, one cycle after the `tx_ready` pulse.
- R9: A sync in mid-frame restarts both walks at entry 0 and discards the unfinished receive byte.
- R10: Addresses 0..DEPTH-1 write the receive table and DEPTH..2*DEPTH-1 write the transmit table, each independently. An entry is {end flag, channel}.
- R11: Outside a transmit slot, `tdm_txd` is driven 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address (tables, then enable) |
| cfg_wdata | input | CH_W+1 | Write data: {end flag, channel}; bit 0 is the enable |
| tdm_bclk | input | 1 | Link bit clock |
| tdm_fsync | input | 1 | Link frame sync, active high |
| tdm_rxd | input | 1 | Link receive data |
| tdm_txd | output | 1 | Link transmit data |
| rx_valid | output | 1 | Received byte strobe |
| rx_chan | output | CH_W | Channel of received byte |
| rx_data | output | DATA_W | Received byte |
| tx_valid | input | NCH | Per-channel transmit byte available |
| tx_data | input | NCH*DATA_W | Per-channel transmit bytes |
| tx_ready | output | NCH | Per-channel fetch strobe |
| tx_underrun | output | NCH | Per-channel underrun strobe |

## Verification
Frames are driven with byte values computed from the frame and slot number, so a bit-order slip, a shifted slot or a swapped channel each give a different word. Several table layouts are used. An in-order table with an end flag on the last entry is compared with a permuted table whose flag ends the walk early, and with a transmit table that has no flag and so wraps at DEPTH. This separates flag handling from depth handling and shows that the two tables are independent. Masks over the channel valid lines pick out which lanes underrun. A frame cut short by an early sync shows whether the walk restarts at entry 0. Every frame carries 40 data bits, so bits beyond the walk's end test that they are ignored and that the line idles low.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  // index of each direction in the table generate loop
  localparam int TBL_RX = 0;
  localparam int TBL_TX = 1;
  localparam int TBL_N  = 2;

  // a table walk ends on a flagged entry or on the final index
  function automatic logic walk_done(input logic last_flag, input logic at_final);
    return last_flag | at_final;
  endfunction
endpackage

// File: rtl/tdm_link_sync.sv
module tdm_link_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk_in,
  input  logic fsync_in,
  input  logic rxd_in,
  output logic rise_p,
  output logic fall_p,
  output logic fsync_s,
  output logic rxd_s
);
  logic [STAGES-1:0] bclk_sr;
  logic [STAGES-1:0] fsync_sr;
  logic [STAGES-1:0] rxd_sr;
  logic              bclk_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) begin
          bclk_sr  <= '0;
          fsync_sr <= '0;
          rxd_sr   <= '0;
        end else begin
          bclk_sr  <= bclk_in;
          fsync_sr <= fsync_in;
          rxd_sr   <= rxd_in;
        end
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) begin
          bclk_sr  <= '0;
          fsync_sr <= '0;
          rxd_sr   <= '0;
        end else begin
          bclk_sr  <= {bclk_sr[STAGES-2:0], bclk_in};
          fsync_sr <= {fsync_sr[STAGES-2:0], fsync_in};
          rxd_sr   <= {rxd_sr[STAGES-2:0], rxd_in};
        end
      end
    end
  endgenerate

  // edge pulses and aligned sync/data, all registered
  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d  <= 1'b0;
      rise_p  <= 1'b0;
      fall_p  <= 1'b0;
      fsync_s <= 1'b0;
      rxd_s   <= 1'b0;
    end else begin
      bclk_d  <= bclk_sr[STAGES-1];
      rise_p  <= bclk_sr[STAGES-1] & ~bclk_d;
      fall_p  <= ~bclk_sr[STAGES-1] & bclk_d;
      fsync_s <= fsync_sr[STAGES-1];
      rxd_s   <= rxd_sr[STAGES-1];
    end
  end
endmodule

// File: rtl/tdm_route_table.sv
module tdm_route_table #(
  parameter int DEPTH   = 4,
  parameter int ENTRY_W = 3,
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_entry
);
  // small distributed memory, no reset so it maps to LUT RAM
  logic [ENTRY_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
  end

  assign rd_entry = mem[rd_idx];
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rise_p,
  input  logic              fsync_s,
  input  logic              rxd_s,
  output logic [IDX_W-1:0]  ent_idx,
  input  logic [CH_W:0]     ent,
  output logic              rx_valid,
  output logic [CH_W-1:0]   rx_chan,
  output logic [DATA_W-1:0] rx_data
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(DEPTH - 1);

  logic              active;
  logic [BIT_W-1:0]  bitc;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] next_sh;

  assign ent_idx = idx;
  assign next_sh = {shreg[DATA_W-2:0], rxd_s};

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active   <= 1'b0;
      bitc     <= '0;
      idx      <= '0;
      shreg    <= '0;
      rx_valid <= 1'b0;
      rx_chan  <= '0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (rise_p) begin
        if (active) begin
          shreg <= next_sh;
          if (bitc == LAST_BIT) begin
            rx_valid <= 1'b1;
            rx_data  <= next_sh;
            rx_chan  <= ent[CH_W-1:0];
            bitc     <= '0;
            if (walk_done(ent[CH_W], idx == FINAL_IDX)) begin
              active <= 1'b0;
              idx    <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            bitc <= bitc + 1'b1;
          end
        end
        // sync wins: the data window opens at the following edge
        if (fsync_s) begin
          active <= 1'b1;
          idx    <= '0;
          bitc   <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DEPTH  = 4,
  parameter int DATA_W = 8,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic                  rise_p,
  input  logic                  fall_p,
  input  logic                  fsync_s,
  output logic [IDX_W-1:0]      ent_idx,
  input  logic [CH_W:0]         ent,
  input  logic [NCH-1:0]        tx_valid,
  input  logic [NCH*DATA_W-1:0] tx_data,
  output logic [NCH-1:0]        tx_ready,
  output logic [NCH-1:0]        tx_underrun,
  output logic                  txd
);
  localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] FINAL_IDX = IDX_W'(DEPTH - 1);

  logic              running;
  logic              loaded;
  logic              done;
  logic              pend;
  logic [IDX_W-1:0]  idx;
  logic [BIT_W-1:0]  bitc;
  logic [DATA_W-1:0] shreg;
  logic [CH_W-1:0]   ch;
  logic [DATA_W-1:0] lane;
  logic [NCH-1:0]    ch_hot;

  assign ent_idx = idx;
  assign ch      = ent[CH_W-1:0];
  assign lane    = tx_data[ch*DATA_W +: DATA_W];
  assign ch_hot  = NCH'(1) << ch;

  // fetch strobe in the cycle after the slot's opening edge
  always_comb begin
    tx_ready = '0;
    if (pend) tx_ready = ch_hot;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      running     <= 1'b0;
      loaded      <= 1'b0;
      done        <= 1'b0;
      pend        <= 1'b0;
      idx         <= '0;
      bitc        <= '0;
      shreg       <= '0;
      txd         <= 1'b0;
      tx_underrun <= '0;
    end else begin
      tx_underrun <= '0;
      if (pend) begin
        pend   <= 1'b0;
        loaded <= 1'b1;
        bitc   <= '0;
        if (tx_valid[ch]) begin
          shreg <= lane;
        end else begin
          shreg       <= '1;
          tx_underrun <= ch_hot;
        end
      end
      if (fall_p) begin
        if (loaded) begin
          txd   <= shreg[DATA_W-1];
          shreg <= {shreg[DATA_W-2:0], 1'b0};
          if (bitc == LAST_BIT) begin
            loaded <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitc <= bitc + 1'b1;
          end
        end else begin
          txd <= 1'b0;
        end
      end
      if (rise_p) begin
        if (fsync_s) begin
          running <= 1'b1;
          idx     <= '0;
          loaded  <= 1'b0;
          done    <= 1'b0;
          pend    <= 1'b1;
        end else if (running && done) begin
          done <= 1'b0;
          if (walk_done(ent[CH_W], idx == FINAL_IDX)) begin
            running <= 1'b0;
            idx     <= '0;
          end else begin
            idx  <= idx + 1'b1;
            pend <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/tdm_slot_if.sv
module tdm_slot_if
  import tdm_pkg::*;
#(
  parameter int NCH         = 4,
  parameter int DEPTH       = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENTRY_W = CH_W + 1,
  localparam int ADDR_W  = $clog2(2 * DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [ENTRY_W-1:0]    cfg_wdata,
  input  logic                  tdm_bclk,
  input  logic                  tdm_fsync,
  input  logic                  tdm_rxd,
  output logic                  tdm_txd,
  output logic                  rx_valid,
  output logic [CH_W-1:0]       rx_chan,
  output logic [DATA_W-1:0]     rx_data,
  input  logic [NCH-1:0]        tx_valid,
  input  logic [NCH*DATA_W-1:0] tx_data,
  output logic [NCH-1:0]        tx_ready,
  output logic [NCH-1:0]        tx_underrun
);
  localparam logic [ADDR_W-1:0] TX_BASE = ADDR_W'(DEPTH);
  localparam logic [ADDR_W-1:0] EN_ADDR = ADDR_W'(2 * DEPTH);

  logic en_q;
  logic rise_p, fall_p, fsync_s, rxd_s;
  logic [ENTRY_W-1:0] ent_rd [TBL_N];
  logic [IDX_W-1:0]   idx_rd [TBL_N];
  logic [TBL_N-1:0]   tbl_we;
  logic [IDX_W-1:0]   tbl_widx [TBL_N];

  // register decode
  assign tbl_we[TBL_RX]   = cfg_we && (cfg_addr < TX_BASE);
  assign tbl_we[TBL_TX]   = cfg_we && (cfg_addr >= TX_BASE) && (cfg_addr < EN_ADDR);
  assign tbl_widx[TBL_RX] = IDX_W'(cfg_addr);
  assign tbl_widx[TBL_TX] = IDX_W'(cfg_addr - TX_BASE);

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else if (cfg_we && cfg_addr == EN_ADDR) en_q <= cfg_wdata[0];
  end

  tdm_link_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bclk_in  (tdm_bclk),
    .fsync_in (tdm_fsync),
    .rxd_in   (tdm_rxd),
    .rise_p   (rise_p),
    .fall_p   (fall_p),
    .fsync_s  (fsync_s),
    .rxd_s    (rxd_s)
  );

  for (genvar d = 0; d < TBL_N; d++) begin : g_tbl
    tdm_route_table #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_tbl (
      .clk      (clk),
      .wr_en    (tbl_we[d]),
      .wr_idx   (tbl_widx[d]),
      .wr_entry (cfg_wdata),
      .rd_idx   (idx_rd[d]),
      .rd_entry (ent_rd[d])
    );
  end

  tdm_rx_framer #(.NCH(NCH), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .en       (en_q),
    .rise_p   (rise_p),
    .fsync_s  (fsync_s),
    .rxd_s    (rxd_s),
    .ent_idx  (idx_rd[TBL_RX]),
    .ent      (ent_rd[TBL_RX]),
    .rx_valid (rx_valid),
    .rx_chan  (rx_chan),
    .rx_data  (rx_data)
  );

  tdm_tx_framer #(.NCH(NCH), .DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx (
    .clk         (clk),
    .rst         (rst),
    .en          (en_q),
    .rise_p      (rise_p),
    .fall_p      (fall_p),
    .fsync_s     (fsync_s),
    .ent_idx     (idx_rd[TBL_TX]),
    .ent         (ent_rd[TBL_TX]),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_ready    (tx_ready),
    .tx_underrun (tx_underrun),
    .txd         (tdm_txd)
  );
endmodule

// File: rtl/tdm_slot_if_chk.sv
module tdm_slot_if_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           en_q,
  input logic           rx_valid,
  input logic [NCH-1:0] tx_ready,
  input logic [NCH-1:0] tx_valid,
  input logic [NCH-1:0] tx_underrun,
  input logic           tdm_txd
);
  // R3: a received byte is presented for a single cycle
  p_rx_single_r3: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  // R7: one channel fetched at a time, for one cycle
  p_ready_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_ready));
  p_ready_single_r7: assert property (@(posedge clk) disable iff (rst)
    (|tx_ready) |=> (tx_ready == '0));

  // R8: an underrun strobe follows a fetch that found no byte
  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (rst)
    (|tx_underrun) |-> $past(|(tx_ready & ~tx_valid)));
  p_underrun_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tx_underrun));

  // R2: quiet while disabled
  p_off_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!en_q && !$past(en_q)) |-> (!rx_valid && tx_ready == '0 && !tdm_txd));
endmodule

bind tdm_slot_if tdm_slot_if_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en_q        (en_q),
  .rx_valid    (rx_valid),
  .tx_ready    (tx_ready),
  .tx_valid    (tx_valid),
  .tx_underrun (tx_underrun),
  .tdm_txd     (tdm_txd)
);

// File: tb/tdm_slot_if_bench.sv
module tdm_slot_if_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [2:0]  cfg_wdata;
  logic        tdm_bclk, tdm_fsync, tdm_rxd, tdm_txd;
  logic        rx_valid;
  logic [1:0]  rx_chan;
  logic [7:0]  rx_data;
  logic [3:0]  tx_valid;
  logic [31:0] tx_data;
  logic [3:0]  tx_ready, tx_underrun;

  tdm_slot_if u_tdm_slot_if (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // capture of port activity
  logic [1:0] cap_ch [8];
  logic [7:0] cap_d  [8];
  int cap_n;
  int rdy_cnt [4];
  int und_cnt [4];

  always @(negedge clk) begin
    if (rx_valid) begin
      if (cap_n < 8) begin
        cap_ch[cap_n] = rx_chan;
        cap_d[cap_n]  = rx_data;
      end
      cap_n++;
    end
    for (int i = 0; i < 4; i++) begin
      if (tx_ready[i]) rdy_cnt[i]++;
      if (tx_underrun[i]) und_cnt[i]++;
    end
  end

  // bench copies of the programmed tables
  int rt [4];
  bit rl [4];
  int tt [4];
  bit tl [4];
  logic [39:0] txv;

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfg_write(input int addr, input logic [2:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(addr); cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic prog_tables();
    for (int k = 0; k < 4; k++) begin
      cfg_write(k, {rl[k], 2'(rt[k])});
      cfg_write(4 + k, {tl[k], 2'(tt[k])});
    end
  endtask

  // one bit period: 8 cycles low then 8 high; txd sampled late in the low half
  task automatic bit_period(input logic s, input logic d, output logic t);
    @(negedge clk);
    tdm_bclk = 1'b0; tdm_fsync = s; tdm_rxd = d;
    repeat (7) @(negedge clk);
    t = tdm_txd;
    @(negedge clk);
    tdm_bclk = 1'b1;
    repeat (7) @(negedge clk);
  endtask

  task automatic clear_counts(input bit with_rx);
    if (with_rx) cap_n = 0;
    for (int i = 0; i < 4; i++) begin rdy_cnt[i] = 0; und_cnt[i] = 0; end
  endtask

  // sync period, 40 data bits, one idle period
  task automatic run_frame(input logic [39:0] rxv);
    logic t;
    bit_period(1'b1, 1'b0, t);
    for (int i = 39; i >= 0; i--) begin
      bit_period(1'b0, rxv[i], t);
      txv[i] = t;
    end
    bit_period(1'b0, 1'b0, t);
  endtask

  function automatic logic [7:0] rx_byte(input int k, input int f);
    return 8'(k * 71 + f * 29 + 90);
  endfunction

  function automatic logic [7:0] lane_byte(input int i, input int f);
    return 8'((i + 1) * 17) ^ 8'(f * 43);
  endfunction

  function automatic logic [63:0] pack4(input int a [4]);
    logic [63:0] p = '0;
    for (int i = 0; i < 4; i++) p[i*8 +: 8] = 8'(a[i]);
    return p;
  endfunction

  // runs one frame and compares every observable against the tables
  task automatic frame_and_check(input int f, input logic [3:0] vmask, input bit clr_rx);
    logic [39:0] rxv, etx;
    int base, nrx, pos;
    int erdy [4];
    int eund [4];
    logic [7:0] b;
    for (int k = 0; k < 5; k++) rxv[39 - 8*k -: 8] = rx_byte(k, f);
    for (int i = 0; i < 4; i++) begin
      tx_data[i*8 +: 8] = lane_byte(i, f);
      erdy[i] = 0; eund[i] = 0;
    end
    tx_valid = vmask;
    clear_counts(clr_rx);
    base = cap_n;
    run_frame(rxv);
    // receive side: R3 data, R4 channel and walk end
    nrx = 0;
    for (int k = 0; k < 4; k++) begin
      nrx++;
      if (rl[k]) break;
    end
    check("R4 rx byte count", 64'(cap_n - base), 64'(nrx));
    for (int k = 0; k < nrx; k++) begin
      check("R3 rx byte value", 64'(cap_d[base + k]), 64'(rx_byte(k, f)));
      check("R4 rx channel tag", 64'(cap_ch[base + k]), 64'(rt[k]));
    end
    // transmit side: R6 order, R7 fetch, R8 underrun, R11 idle low
    etx = '0; pos = 39;
    for (int k = 0; k < 4; k++) begin
      erdy[tt[k]]++;
      if (vmask[tt[k]]) b = lane_byte(tt[k], f);
      else begin b = 8'hFF; eund[tt[k]]++; end
      for (int j = 7; j >= 0; j--) begin etx[pos] = b[j]; pos--; end
      if (tl[k]) break;
    end
    check("R6/R11 tx bit stream", 64'(txv), 64'(etx));
    check("R7 fetch strobes per channel", pack4(rdy_cnt), pack4(erdy));
    check("R8 underrun strobes per channel", pack4(und_cnt), pack4(eund));
  endtask

  initial begin
    logic t;
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    tdm_bclk = 1'b0; tdm_fsync = 1'b0; tdm_rxd = 1'b0;
    tx_valid = '0; tx_data = '0;
    cap_n = 0; clear_counts(1'b1);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1 outputs after reset",
          {60'(0), rx_valid, |tx_ready, |tx_underrun, tdm_txd}, 64'(0));

    // R2: tables programmed, enable still 0
    for (int k = 0; k < 4; k++) begin
      rt[k] = k; rl[k] = (k == 3); tt[k] = k; tl[k] = (k == 3);
    end
    prog_tables();
    tx_valid = 4'hF; tx_data = 32'h1234_5678;
    clear_counts(1'b1);
    run_frame(40'hA5_C3_5A_3C_F0);
    check("R2 no rx while disabled", 64'(cap_n), 64'(0));
    check("R2 no fetch while disabled", pack4(rdy_cnt), 64'(0));
    check("R2 txd low while disabled", 64'(txv), 64'(0));

    cfg_write(8, 3'b001);
    // R3 R4 R6 R7: in-order tables, several data patterns
    for (int f = 0; f < 4; f++) frame_and_check(f, 4'hF, 1'b1);

    // R10 and R5: permuted rx table ended early, tx table without end flag
    rt[0] = 3; rt[1] = 1; rt[2] = 0; rt[3] = 2;
    rl[0] = 0; rl[1] = 0; rl[2] = 1; rl[3] = 0;
    tt[0] = 2; tt[1] = 2; tt[2] = 1; tt[3] = 0;
    for (int k = 0; k < 4; k++) tl[k] = 0;
    prog_tables();
    for (int f = 4; f < 6; f++) begin
      frame_and_check(f, 4'hF, 1'b1);
      check("R10 rx walk independent of tx table", 64'(cap_n), 64'(3));
      check("R5 tx walk wraps after last entry", 64'(rdy_cnt[0] + rdy_cnt[1] + rdy_cnt[2]), 64'(4));
      check("R11 txd low after walk end", 64'(txv[7:0]), 64'(0));
    end

    // R8: underrun patterns on in-order tables
    for (int k = 0; k < 4; k++) begin
      rt[k] = k; rl[k] = (k == 3); tt[k] = k; tl[k] = (k == 3);
    end
    prog_tables();
    frame_and_check(6, 4'b1101, 1'b1);
    frame_and_check(7, 4'b0000, 1'b1);
    frame_and_check(8, 4'b1010, 1'b1);

    // R9: frame cut after 12 bits by a new sync
    tx_valid = 4'hF;
    clear_counts(1'b1);
    bit_period(1'b1, 1'b0, t);
    for (int i = 11; i >= 0; i--) bit_period(1'b0, logic'(12'hC39 >> i), t);
    frame_and_check(9, 4'hF, 1'b0);
    check("R9 byte before cut delivered", 64'(cap_d[0]), 64'(8'hC3));
    check("R9 total bytes after resync", 64'(cap_n), 64'(5));

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule